// File: doc/BRIEF.md
# Predicted-Carry Modular Adder and Subtractor

This block adds or subtracts two residues of a fixed modulus m and returns the residue of the result. The modulus is set at build time. Operands are n-bit values already reduced into [0, m). The modulus must satisfy 2^(n-1) < m <= 2^n, so that one correction step always brings the result back into range.

In add mode the block adds the constant Z = 2^n - m to the operands in carry-save form and looks ahead to the carry-out of A + B + Z. When that carry is set, the answer is the low n bits of A + B + Z. Otherwise the answer is the plain sum A + B. In subtract mode, B enters as its one's complement with a carry-in of one. The carry-out of A - B decides whether m is added back.

For each operation there are two candidate propagate/generate vectors. The predicted carry picks one of them before a single carry chain and sum stage. This avoids building two complete adders and choosing between their outputs. The block has no state: the result follows the inputs within the same cycle.

Top module: `modadd_predict`

## Requirements
- R1: In add mode (`sub_i` = 0), with both operands in [0, m), `res_o` equals (A + B) mod m.
- R2: In subtract mode (`sub_i` = 1), with both operands in [0, m), `res_o` equals (A - B) mod m, taken as a value in [0, m).
- R3: For in-range operands, `res_o` is always less than m.
- R4: When A + B is at least m, the add result is A + B - m; for example (m-1) + 1 gives 0.
- R5: When A is less than B, the subtract result is A - B + m; for example 0 - 1 gives m - 1.
- R6: An operand B of zero returns A unchanged in both modes.
- R7: Subtracting a value from itself gives 0.
- R8: The same structure is correct for m = 2^n (the correction constant is zero, so results are the low n bits of the binary sum or difference) and for m = 2^n - 1.
- R9: The block has no state. A new input pattern produces its result within the same clock period, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | N | First residue, in [0, m) |
| b_i | input | N | Second residue, in [0, m) |
| sub_i | input | 1 | Operation select: 0 adds, 1 subtracts (B from A) |
| res_o | output | N | Residue of the sum or difference |

## Verification
Every result is due in the same cycle as its stimulus, since there is no register between the inputs and `res_o`. The bench changes the operands at a falling clock edge and samples `res_o` one nanosecond later, well before the next rising edge. No check can therefore depend on a clock edge or on process order. Full sweeps over both modes cover moduli 5, 7, 8 and 15 at small widths. A vector table covers the default 8-bit modulus 251, including wrap and borrow cases at both ends of the range.

// File: rtl/modadd_pkg.sv
// Package: shared definitions for the predicted-carry modular adder.
// Assumes nothing beyond IEEE 1800-2017 packages.
package modadd_pkg;

    // Operation encoding carried on the select input.
    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } modop_e;

endpackage

// File: rtl/modadd_bitcell.sv
// Module: one bit of the carry-save stage that folds a constant bit into
// the two operand bits. With k_i low it is a half adder (XOR / AND); with
// k_i high it yields XNOR / OR, i.e. a full adder whose third input is 1.
// Assumes k_i is a constant or slowly changing select.
module modadd_bitcell (
    input  logic a_i,
    input  logic b_i,
    input  logic k_i,
    output logic hs_o,
    output logic cy_o
);

    // Half-sum and carry for the two constant-bit variants.
    always_comb begin
        if (k_i) begin
            hs_o = ~(a_i ^ b_i);
            cy_o = a_i | b_i;
        end else begin
            hs_o = a_i ^ b_i;
            cy_o = a_i & b_i;
        end
    end

endmodule

// File: rtl/modadd_lookahead.sv
// Module: carry-out of a W-bit propagate/generate vector with carry-in.
// Group propagate and generate are formed by a log-depth prefix tree.
// Assumes W >= 1.
module modadd_lookahead #(
    parameter int W = 8
) (
    input  logic [W-1:0] p_i,
    input  logic [W-1:0] g_i,
    input  logic         cin_i,
    output logic         cout_o
);

    localparam int LVL = (W > 1) ? $clog2(W) : 1;

    logic [W-1:0] pl [LVL+1];
    logic [W-1:0] gl [LVL+1];

    assign pl[0] = p_i;
    assign gl[0] = g_i;

    // Each prefix level doubles the span covered by every position.
    for (genvar l = 0; l < LVL; l++) begin : g_level
        for (genvar i = 0; i < W; i++) begin : g_bit
            if (i >= (1 << l)) begin : g_merge
                assign gl[l+1][i] = gl[l][i] | (pl[l][i] & gl[l][i-(1<<l)]);
                assign pl[l+1][i] = pl[l][i] & pl[l][i-(1<<l)];
            end else begin : g_pass
                assign gl[l+1][i] = gl[l][i];
                assign pl[l+1][i] = pl[l][i];
            end
        end
    end

    // Whole-word carry-out including the carry-in.
    assign cout_o = gl[LVL][W-1] | (pl[LVL][W-1] & cin_i);

endmodule

// File: rtl/modadd_sumstage.sv
// Module: shared carry chain and sum stage. Forms every internal carry
// from the selected propagate/generate pair and XORs it into the sum.
// Assumes W >= 1; the final carry-out is not needed by the caller.
module modadd_sumstage #(
    parameter int W = 8
) (
    input  logic [W-1:0] p_i,
    input  logic [W-1:0] g_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o
);

    logic [W:0] carry;

    // Carry into each bit position, starting from the carry-in.
    always_comb begin
        carry[0] = cin_i;
        for (int i = 0; i < W; i++) begin
            carry[i+1] = g_i[i] | (p_i[i] & carry[i]);
        end
    end

    // Sum bit is propagate XOR incoming carry.
    assign sum_o = p_i ^ carry[W-1:0];

endmodule

// File: rtl/modadd_predict.sv
// Module: modular adder/subtractor for a fixed modulus MODULUS with
// N-bit residues. It predicts the carry of the corrected sum and routes
// one of two propagate/generate pairs into a single sum stage.
// Assumes 2**(N-1) < MODULUS <= 2**N, N >= 2, operands below MODULUS.
module modadd_predict #(
    parameter int N       = 8,
    parameter int MODULUS = 251
) (
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] b_i,
    input  logic         sub_i,
    output logic [N-1:0] res_o
);

    import modadd_pkg::*;

    localparam int          ZVAL  = (1 << N) - MODULUS;
    localparam logic [N-1:0] K_ADD = N'(ZVAL);
    localparam logic [N-1:0] K_SUB = N'(MODULUS);

    modop_e       op;
    logic [N-1:0] opb;
    logic [N-1:0] kvec;
    logic [N-1:0] hs;
    logic [N-1:0] cy;
    logic [N-1:0] csh;
    logic [N-1:0] px, gx, py, gy;
    logic [N-1:0] pp, gp;
    logic [N-1:0] ps, gs;
    logic         pred_cout;
    logic         take_y;
    logic         cin_s;

    // Decode the select and prepare the second operand and the constant.
    always_comb begin
        op   = modop_e'(sub_i);
        opb  = (op == OP_SUB) ? ~b_i  : b_i;
        kvec = (op == OP_SUB) ? K_SUB : K_ADD;
    end

    // Carry-save cells fold the correction constant into the operands.
    for (genvar i = 0; i < N; i++) begin : g_cell
        modadd_bitcell u_cell (
            .a_i  (a_i[i]),
            .b_i  (opb[i]),
            .k_i  (kvec[i]),
            .hs_o (hs[i]),
            .cy_o (cy[i])
        );
    end

    // Candidate propagate/generate pairs: X without, Y with the constant.
    always_comb begin
        px  = a_i ^ opb;
        gx  = a_i & opb;
        csh = {cy[N-2:0], sub_i};
        py  = hs ^ csh;
        gy  = hs & csh;
    end

    // Prediction looks at Y when adding and at X when subtracting.
    always_comb begin
        pp = (op == OP_SUB) ? px : py;
        gp = (op == OP_SUB) ? gx : gy;
    end

    modadd_lookahead #(.W(N)) u_predict (
        .p_i    (pp),
        .g_i    (gp),
        .cin_i  (sub_i),
        .cout_o (pred_cout)
    );

    // Pick the pair for the sum stage from the predicted carry.
    always_comb begin
        if (op == OP_SUB) take_y = ~pred_cout;
        else              take_y = pred_cout | cy[N-1];
        ps    = take_y ? py : px;
        gs    = take_y ? gy : gx;
        cin_s = take_y ? 1'b0 : sub_i;
    end

    modadd_sumstage #(.W(N)) u_sum (
        .p_i   (ps),
        .g_i   (gs),
        .cin_i (cin_s),
        .sum_o (res_o)
    );

endmodule

// File: rtl/modadd_predict_chk.sv
// Module: checker for modadd_predict, attached by bind. It compares the
// result against arithmetic on the ports whenever the inputs are known
// and in range. Assumes the same parameters as the checked instance.
module modadd_predict_chk #(
    parameter int N       = 8,
    parameter int MODULUS = 251
) (
    input logic [N-1:0] a_i,
    input logic [N-1:0] b_i,
    input logic         sub_i,
    input logic [N-1:0] res_o
);

    // Port-level arithmetic checks on every settled input pattern.
    always_comb begin
        int ua;
        int ub;
        int rv;
        ua = int'(a_i);
        ub = int'(b_i);
        rv = int'(res_o);
        if (!$isunknown({a_i, b_i, sub_i, res_o}) && ua < MODULUS && ub < MODULUS) begin
            if (!sub_i) AST_ADD_MATCH: assert (rv == (ua + ub) % MODULUS);       // R1
            if (sub_i)  AST_SUB_MATCH: assert (rv == (ua - ub + MODULUS) % MODULUS); // R2
            AST_BELOW_MOD: assert (rv < MODULUS);                                 // R3
            if (ub == 0) AST_ZERO_OPERAND: assert (rv == ua);                     // R6
            if (sub_i && ua == ub) AST_SELF_CANCEL: assert (rv == 0);             // R7
        end
    end

endmodule

bind modadd_predict modadd_predict_chk #(.N(N), .MODULUS(MODULUS)) u_chk (
    .a_i   (a_i),
    .b_i   (b_i),
    .sub_i (sub_i),
    .res_o (res_o)
);

// File: tb/modadd_predict_tb.sv
module modadd_predict_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;

    // Default instance: N = 8, m = 251.
    logic [7:0] a8, b8, r8;
    logic       s8;
    modadd_predict #(.N(8), .MODULUS(251)) u_dut (
        .a_i(a8), .b_i(b8), .sub_i(s8), .res_o(r8));

    logic [2:0] a5, b5, r5;
    logic       s5;
    modadd_predict #(.N(3), .MODULUS(5)) u_m5 (
        .a_i(a5), .b_i(b5), .sub_i(s5), .res_o(r5));

    logic [2:0] a7, b7, r7;
    logic       s7;
    modadd_predict #(.N(3), .MODULUS(7)) u_m7 (
        .a_i(a7), .b_i(b7), .sub_i(s7), .res_o(r7));

    logic [2:0] a8m, b8m, r8m;
    logic       s8m;
    modadd_predict #(.N(3), .MODULUS(8)) u_m8 (
        .a_i(a8m), .b_i(b8m), .sub_i(s8m), .res_o(r8m));

    logic [3:0] a15, b15, r15;
    logic       s15;
    modadd_predict #(.N(4), .MODULUS(15)) u_m15 (
        .a_i(a15), .b_i(b15), .sub_i(s15), .res_o(r15));

    // Vectors for m = 251: {a, b, sub, expected}.
    localparam int NVEC = 12;
    localparam logic [24:0] VEC [NVEC] = '{
        {8'd10,  8'd20,  1'b0, 8'd30 },   // R1 no wrap
        {8'd250, 8'd1,   1'b0, 8'd0  },   // R4 wrap to zero
        {8'd250, 8'd250, 1'b0, 8'd249},   // R4 largest sum
        {8'd200, 8'd100, 1'b0, 8'd49 },   // R4 carry beyond 2^n
        {8'd128, 8'd127, 1'b0, 8'd4  },   // R4 sum under 2^n but over m
        {8'd125, 8'd125, 1'b0, 8'd250},   // R1 just below m
        {8'd0,   8'd0,   1'b0, 8'd0  },   // R6
        {8'd30,  8'd10,  1'b1, 8'd20 },   // R2 no borrow
        {8'd10,  8'd30,  1'b1, 8'd231},   // R5 borrow
        {8'd0,   8'd1,   1'b1, 8'd250},   // R5 zero minus one
        {8'd250, 8'd250, 1'b1, 8'd0  },   // R7
        {8'd0,   8'd250, 1'b1, 8'd1  }    // R5 largest borrow
    };

    function automatic int ref_mod(int a, int b, bit sub, int m);
        return sub ? (a - b + m) % m : (a + b) % m;
    endfunction

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        a8 = '0; b8 = '0; s8 = 1'b0;
        a5 = '0; b5 = '0; s5 = 1'b0;
        a7 = '0; b7 = '0; s7 = 1'b0;
        a8m = '0; b8m = '0; s8m = 1'b0;
        a15 = '0; b15 = '0; s15 = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // Idle state: zero operands give zero (R6).
        @(negedge clk); #1;
        check("R6 idle", int'(r8), 0);

        // Table walk on the default modulus.
        for (int k = 0; k < NVEC; k++) begin
            @(negedge clk);
            {a8, b8, s8} = VEC[k][24:8];
            #1;
            check($sformatf("R1/R2 vec%0d", k), int'(r8), int'(VEC[k][7:0]));
        end

        // R9: two patterns within one period, no clock edge between them.
        @(negedge clk);
        a8 = 8'd100; b8 = 8'd200; s8 = 1'b0;
        #1;
        check("R9 first", int'(r8), 49);
        a8 = 8'd100; b8 = 8'd200; s8 = 1'b1;
        #1;
        check("R9 second", int'(r8), 151);

        // Exhaustive sweeps on small moduli.
        for (int sm = 0; sm < 2; sm++) begin
            for (int a = 0; a < 15; a++) begin
                for (int b = 0; b < 15; b++) begin
                    @(negedge clk);
                    a15 = 4'(a); b15 = 4'(b); s15 = sm[0];
                    a5 = 3'(a % 5); b5 = 3'(b % 5); s5 = sm[0];
                    a7 = 3'(a % 7); b7 = 3'(b % 7); s7 = sm[0];
                    a8m = 3'(a % 8); b8m = 3'(b % 8); s8m = sm[0];
                    #1;
                    check(sm[0] ? "R2 m15 (R8)" : "R1 m15 (R8)", int'(r15),
                          ref_mod(a, b, sm[0], 15));
                    check(sm[0] ? "R2 m5" : "R1 m5", int'(r5),
                          ref_mod(a % 5, b % 5, sm[0], 5));
                    check(sm[0] ? "R2 m7" : "R1 m7", int'(r7),
                          ref_mod(a % 7, b % 7, sm[0], 7));
                    check("R3 m7 range", (int'(r7) < 7) ? 1 : 0, 1);
                    check(sm[0] ? "R8 m8 sub" : "R8 m8 add", int'(r8m),
                          sm[0] ? ((a % 8) - (b % 8)) & 7 : ((a % 8) + (b % 8)) & 7);
                end
            end
        end

        // Corner cases on m = 5: wrap, borrow, zero operand, self cancel.
        @(negedge clk); a5 = 3'd4; b5 = 3'd1; s5 = 1'b0; #1;
        check("R4 m5 wrap", int'(r5), 0);
        @(negedge clk); a5 = 3'd0; b5 = 3'd1; s5 = 1'b1; #1;
        check("R5 m5 borrow", int'(r5), 4);
        @(negedge clk); a5 = 3'd3; b5 = 3'd0; s5 = 1'b1; #1;
        check("R6 m5 zero sub", int'(r5), 3);
        @(negedge clk); a5 = 3'd4; b5 = 3'd4; s5 = 1'b1; #1;
        check("R7 m5 self", int'(r5), 0);

        finish_run();
    end

endmodule